// File: doc/BRIEF.md
# Column Offset Calibration and Correction

This block removes column-wise fixed offset from a raster pixel stream. Each incoming 12-bit pixel has an 8-bit coefficient subtracted from it. The coefficient belongs to the pixel's column. Pixels arrive with a line-valid and a frame-valid qualifier, and the corrected stream leaves one clock later with the same qualifiers delayed to match. The column index counts the cycles of the current line, starting at 0 on the first cycle where line-valid is high.

There are two sources of coefficients. The first is a dark-frame calibration, which software requests with a start pulse while the sensor sees no light. The block waits for the next frame. It accumulates every column over the first `CAL_LINES` lines of that frame. It then stores the floor of each column's mean as that column's coefficient. The second source is an online table, rebuilt on every frame from the first `MASK_LINES` lines flagged as optically masked. A per-column accumulator memory, updated by read-modify-write, serves both sources. Averages that do not fit the 8-bit coefficient range are clamped and reported through sticky flags. Any new table takes effect at the next frame start, so a frame in flight is never corrected with a mix of two tables.

Top module: `fpn_col_corrector`

## Requirements
- R1: After reset, pixOut, lineValidOut, frameValidOut, calDone, ovfFlag and unfFlag are 0, and both coefficient tables hold 0.
- R2: With corrMode 00 or 10, pixOut equals the pixIn of the previous cycle whenever lineValidOut is high.
- R3: With corrMode 01, pixOut is the previous cycle's pixIn minus the offline coefficient of that pixel's column. With corrMode 11, the online coefficient is used instead.
- R4: When the selected coefficient exceeds the pixel, pixOut is 0 and never wraps.
- R5: A calibration request is a calStart cycle, accepted only while no calibration is pending. The first rising frameValid after an accepted request starts the calibration. The offline coefficient of column c becomes floor(sum over the first CAL_LINES lines of that frame / CAL_LINES).
- R6: A column whose average is 0 gets coefficient 0 and sets unfFlag.
- R7: A column whose average exceeds 255 gets coefficient 255 and sets ovfFlag.
- R8: calDone is high for exactly one cycle. That cycle is the one after the first cycle in which lineValid is low at the end of the last calibration line.
- R9: calStart is ignored while fullRes is low or while a calibration is armed or running.
- R10: New coefficients of either table take effect only at the next rising frameValid. Pixels of the current frame keep the old table. frameValid must rise at least one cycle before the first lineValid of the frame.
- R11: With corrMode 11, each frame averages the first MASK_LINES lines that have maskedLine high, using the same clamping, and applies the result from the next frame. Further masked lines in that frame are ignored, and online accumulation pauses while a calibration runs.
- R12: ovfFlag and unfFlag stay set until reset.
- R13: lineValidOut and frameValidOut are lineValid and frameValid delayed by one cycle, and pixOut is 0 while lineValidOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pixIn | input | PIX_W | Incoming pixel |
| lineValid | input | 1 | Pixel qualifier within a line |
| frameValid | input | 1 | Frame qualifier |
| maskedLine | input | 1 | Current line comes from optically masked rows |
| fullRes | input | 1 | Readout region is the full array |
| calStart | input | 1 | Calibration request |
| corrMode | input | 2 | 00 off, 01 offline table, 11 online table, 10 off |
| pixOut | output | PIX_W | Corrected pixel |
| lineValidOut | output | 1 | Delayed line qualifier |
| frameValidOut | output | 1 | Delayed frame qualifier |
| calDone | output | 1 | One-cycle calibration completion pulse |
| ovfFlag | output | 1 | Sticky: some average exceeded 255 |
| unfFlag | output | 1 | Sticky: some average was 0 |

## Verification
A wrong accumulator or staging entry stays hidden until the next frame start, so it shows up at pixOut only in the frame after a calibration or masked-line frame. The bench therefore always follows each calibration or online frame with a corrected frame and compares every pixel. A stuck calibration state shows in the same way: calDone arrives in the wrong cycle or not at all, which is visible one cycle after the last calibration line. Clamp errors appear as flag mismatches at the end of the calibration frame, and also as 0 or 255 coefficients on the designated dark and bright columns.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_RUN   = 2'd2
  } calState_t;

  typedef struct packed {
    logic accEn;      // accumulate the current pixel
    logic accFirst;   // first line of a window: overwrite the sum
    logic accLast;    // last line of a window: write the average
    logic useCal;     // window belongs to the offline calibration
    logic commitOff;  // copy offline staging to the live table
    logic commitOn;   // copy online staging to the live table
  } fpnStrobes_t;

  localparam logic [1:0] MODE_OFFLINE = 2'b01;
  localparam logic [1:0] MODE_ONLINE  = 2'b11;

endpackage

// File: rtl/fpn_col_ctrl.sv
module fpn_col_ctrl
  import fpn_pkg::*;
#(
  parameter int CAL_LINES  = 1024,
  parameter int MASK_LINES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineValid,
  input  logic        frameValid,
  input  logic        maskedLine,
  input  logic        fullRes,
  input  logic        calStart,
  input  logic [1:0]  corrMode,
  output fpnStrobes_t strb,
  output logic        calDone
);

  localparam int CAL_CW = $clog2(CAL_LINES + 1);
  localparam int ON_CW  = $clog2(MASK_LINES + 1);

  calState_t         state;
  logic [CAL_CW-1:0] calLine;
  logic [ON_CW-1:0]  onCnt;
  logic lvPrev, fvPrev, lineOnline, pendOff, pendOn;

  logic frameStart, frameEnd, lineEnd, onAcc, calLastLine, onLastLine;

  always_comb begin
    frameStart  = frameValid & ~fvPrev;
    frameEnd    = ~frameValid & fvPrev;
    lineEnd     = ~lineValid & lvPrev;
    calLastLine = (calLine == CAL_CW'(CAL_LINES - 1));
    onLastLine  = (onCnt == ON_CW'(MASK_LINES - 1));
    onAcc       = (corrMode == MODE_ONLINE) && (state != CAL_RUN) &&
                  maskedLine && (onCnt < ON_CW'(MASK_LINES));
    strb = '0;
    if (state == CAL_RUN) begin
      strb.accEn    = lineValid;
      strb.accFirst = (calLine == '0);
      strb.accLast  = calLastLine;
      strb.useCal   = 1'b1;
    end else begin
      strb.accEn    = lineValid & onAcc;
      strb.accFirst = (onCnt == '0);
      strb.accLast  = onLastLine;
    end
    strb.commitOff = frameStart & pendOff;
    strb.commitOn  = frameStart & pendOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= CAL_IDLE;
      calLine    <= '0;
      onCnt      <= '0;
      lvPrev     <= 1'b0;
      fvPrev     <= 1'b0;
      lineOnline <= 1'b0;
      pendOff    <= 1'b0;
      pendOn     <= 1'b0;
      calDone    <= 1'b0;
    end else begin
      lvPrev  <= lineValid;
      fvPrev  <= frameValid;
      calDone <= 1'b0;

      case (state)
        CAL_IDLE:  if (calStart && fullRes) state <= CAL_ARMED;
        CAL_ARMED: if (frameStart) begin
                     state   <= CAL_RUN;
                     calLine <= '0;
                   end
        CAL_RUN: begin
          if (lineEnd && calLastLine) begin
            state   <= CAL_IDLE;
            calDone <= 1'b1;
            pendOff <= 1'b1;
          end else if (lineEnd) begin
            calLine <= calLine + 1'b1;
          end else if (frameEnd) begin
            state <= CAL_ARMED;
          end
        end
        default: state <= CAL_IDLE;
      endcase

      if (lineValid && onAcc) lineOnline <= 1'b1;
      else if (lineEnd)       lineOnline <= 1'b0;

      if (frameStart) begin
        onCnt <= '0;
      end else if (lineEnd && lineOnline) begin
        onCnt <= onCnt + 1'b1;
        if (onLastLine) pendOn <= 1'b1;
      end

      if (strb.commitOff) pendOff <= 1'b0;
      if (strb.commitOn)  pendOn  <= 1'b0;
    end
  end

  logic chkArmed;
  always_ff @(posedge clk) chkArmed <= rstN;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> !calDone);
  p_done_after_line_r8: assert property (@(posedge clk) disable iff (!rstN || !chkArmed)
    calDone |-> ($past(lvPrev) && !$past(lineValid)));
  p_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == CAL_IDLE && calStart && !fullRes) |=> state == CAL_IDLE);
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == CAL_RUN && !lineEnd && !frameEnd) |=> state == CAL_RUN);

endmodule

// File: rtl/fpn_col_datapath.sv
module fpn_col_datapath
  import fpn_pkg::*;
#(
  parameter int NUM_COLS   = 2048,
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 8,
  parameter int CAL_LINES  = 1024,
  parameter int MASK_LINES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             lineValid,
  input  logic             frameValid,
  input  logic [1:0]       corrMode,
  input  fpnStrobes_t      strb,
  output logic [PIX_W-1:0] pixOut,
  output logic             lvOut,
  output logic             fvOut,
  output logic             ovfFlag,
  output logic             unfFlag
);

  localparam int IDX_W    = $clog2(NUM_COLS);
  localparam int COL_W    = IDX_W + 1;
  localparam int CAL_SH   = $clog2(CAL_LINES);
  localparam int ON_SH    = $clog2(MASK_LINES);
  localparam int SUM_W    = PIX_W + CAL_SH;
  localparam logic [COEF_W-1:0] COEF_MAX = '1;

  logic [SUM_W-1:0]  accMem   [NUM_COLS];
  logic [COEF_W-1:0] offStage [NUM_COLS];
  logic [COEF_W-1:0] onStage  [NUM_COLS];
  logic [COEF_W-1:0] offCoef  [NUM_COLS];
  logic [COEF_W-1:0] onCoef   [NUM_COLS];

  logic [COL_W-1:0]  colIdx;
  logic [IDX_W-1:0]  idx;
  logic              inRange;
  logic [SUM_W-1:0]  sumNext, avgRaw;
  logic              avgLow, avgHigh;
  logic [COEF_W-1:0] avgCoef, coefSel;
  logic [PIX_W-1:0]  coefExt, corrected;

  always_comb begin
    idx     = colIdx[IDX_W-1:0];
    inRange = (colIdx < COL_W'(NUM_COLS));
    sumNext = (strb.accFirst ? '0 : accMem[idx]) + SUM_W'(pixIn);
    avgRaw  = strb.useCal ? (sumNext >> CAL_SH) : (sumNext >> ON_SH);
    avgLow  = (avgRaw == '0);
    avgHigh = (avgRaw > SUM_W'(COEF_MAX));
    avgCoef = avgHigh ? COEF_MAX : avgRaw[COEF_W-1:0];
    coefSel = '0;
    if (inRange) begin
      if (corrMode == MODE_OFFLINE)     coefSel = offCoef[idx];
      else if (corrMode == MODE_ONLINE) coefSel = onCoef[idx];
    end
    coefExt   = PIX_W'(coefSel);
    corrected = (pixIn >= coefExt) ? (pixIn - coefExt) : '0;
  end

  always_ff @(posedge clk) begin
    if (strb.accEn && inRange && !strb.accLast) accMem[idx] <= sumNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut  <= '0;
      lvOut   <= 1'b0;
      fvOut   <= 1'b0;
      colIdx  <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
      for (int i = 0; i < NUM_COLS; i++) begin
        offStage[i] <= '0;
        onStage[i]  <= '0;
        offCoef[i]  <= '0;
        onCoef[i]   <= '0;
      end
    end else begin
      lvOut  <= lineValid;
      fvOut  <= frameValid;
      pixOut <= lineValid ? corrected : '0;
      if (!lineValid)   colIdx <= '0;
      else if (inRange) colIdx <= colIdx + 1'b1;

      if (strb.accEn && inRange && strb.accLast) begin
        if (strb.useCal) offStage[idx] <= avgCoef;
        else             onStage[idx]  <= avgCoef;
        if (avgLow)  unfFlag <= 1'b1;
        if (avgHigh) ovfFlag <= 1'b1;
      end
      if (strb.commitOff) offCoef <= offStage;
      if (strb.commitOn)  onCoef  <= onStage;
    end
  end

  logic chkArmed;
  always_ff @(posedge clk) chkArmed <= rstN;

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN || !chkArmed)
    (lvOut && !$past(corrMode[0])) |-> pixOut == $past(pixIn));
  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rstN || !chkArmed)
    lvOut |-> pixOut <= $past(pixIn));
  p_offhold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitOff |=> $stable(offCoef[0]));
  p_onhold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitOn |=> $stable(onCoef[0]));
  p_sticky_ovf_r12: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  p_sticky_unf_r12: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |=> unfFlag);
  p_align_r13: assert property (@(posedge clk) disable iff (!rstN || !chkArmed)
    (lvOut == $past(lineValid)) && (fvOut == $past(frameValid)));
  p_blank_r13: assert property (@(posedge clk) disable iff (!rstN)
    !lvOut |-> pixOut == '0);

endmodule

// File: rtl/fpn_col_corrector.sv
module fpn_col_corrector
  import fpn_pkg::*;
#(
  parameter int NUM_COLS   = 2048,
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 8,
  parameter int CAL_LINES  = 1024,
  parameter int MASK_LINES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             lineValid,
  input  logic             frameValid,
  input  logic             maskedLine,
  input  logic             fullRes,
  input  logic             calStart,
  input  logic [1:0]       corrMode,
  output logic [PIX_W-1:0] pixOut,
  output logic             lineValidOut,
  output logic             frameValidOut,
  output logic             calDone,
  output logic             ovfFlag,
  output logic             unfFlag
);

  fpnStrobes_t strb;

  fpn_col_ctrl #(
    .CAL_LINES (CAL_LINES),
    .MASK_LINES(MASK_LINES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineValid (lineValid),
    .frameValid(frameValid),
    .maskedLine(maskedLine),
    .fullRes   (fullRes),
    .calStart  (calStart),
    .corrMode  (corrMode),
    .strb      (strb),
    .calDone   (calDone)
  );

  fpn_col_datapath #(
    .NUM_COLS  (NUM_COLS),
    .PIX_W     (PIX_W),
    .COEF_W    (COEF_W),
    .CAL_LINES (CAL_LINES),
    .MASK_LINES(MASK_LINES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pixIn     (pixIn),
    .lineValid (lineValid),
    .frameValid(frameValid),
    .corrMode  (corrMode),
    .strb      (strb),
    .pixOut    (pixOut),
    .lvOut     (lineValidOut),
    .fvOut     (frameValidOut),
    .ovfFlag   (ovfFlag),
    .unfFlag   (unfFlag)
  );

endmodule

// File: tb/tb_fpn_col_corrector.sv
module tb_fpn_col_corrector;

  localparam int NC = 8;
  localparam int PW = 12;
  localparam int CL = 16;
  localparam int ML = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PW-1:0] pixIn = '0;
  logic lineValid = 1'b0, frameValid = 1'b0, maskedLine = 1'b0;
  logic fullRes = 1'b0, calStart = 1'b0;
  logic [1:0] corrMode = 2'b00;
  logic [PW-1:0] pixOut;
  logic lineValidOut, frameValidOut, calDone, ovfFlag, unfFlag;

  always #4 clk = ~clk;

  fpn_col_corrector #(.NUM_COLS(NC), .PIX_W(PW), .COEF_W(8),
                      .CAL_LINES(CL), .MASK_LINES(ML)) dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .lineValid(lineValid),
    .frameValid(frameValid), .maskedLine(maskedLine), .fullRes(fullRes),
    .calStart(calStart), .corrMode(corrMode), .pixOut(pixOut),
    .lineValidOut(lineValidOut), .frameValidOut(frameValidOut),
    .calDone(calDone), .ovfFlag(ovfFlag), .unfFlag(unfFlag));

  int nChecks = 0;
  int nFail = 0;
  string curTag = "R2";

  // behavioural reference state
  int offCoefM[NC], onCoefM[NC], offStM[NC], onStM[NC], sumCal[NC], sumOn[NC];
  bit pendOffM = 0, pendOnM = 0, lineOnM = 0, prevLv = 0, prevFv = 0;
  bit ovfM = 0, unfM = 0;
  int calStM = 0, calLineM = 0, onCntM = 0, colM = 0;

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampAvg(int s, int d);
    int a = s / d;
    if (a < 1) begin unfM = 1; return 0; end
    if (a > 255) begin ovfM = 1; return 255; end
    return a;
  endfunction

  task automatic tick(bit lv, bit fv, int pix, bit msk, bit cs);
    int ePix = 0;
    int coef = 0;
    bit eDone = 0;
    bit fStart = fv && !prevFv;
    bit fEnd = !fv && prevFv;
    bit lEnd = !lv && prevLv;
    string tag;
    lineValid = lv; frameValid = fv; pixIn = PW'(pix); maskedLine = msk; calStart = cs;
    tag = curTag;
    if (lv) begin
      if (colM < NC) begin
        if (corrMode == 2'b01) coef = offCoefM[colM];
        else if (corrMode == 2'b11) coef = onCoefM[colM];
      end
      ePix = (pix >= coef) ? pix - coef : 0;
      if (pix < coef) tag = "R4";
      if (calStM == 2) begin
        if (colM < NC) sumCal[colM] = (calLineM == 0) ? pix : sumCal[colM] + pix;
      end else if (corrMode == 2'b11 && msk && onCntM < ML) begin
        if (colM < NC) sumOn[colM] = (onCntM == 0) ? pix : sumOn[colM] + pix;
        lineOnM = 1;
      end
      colM++;
    end else colM = 0;
    if (lEnd) begin
      if (calStM == 2) begin
        if (calLineM == CL - 1) begin
          for (int c = 0; c < NC; c++) offStM[c] = clampAvg(sumCal[c], CL);
          pendOffM = 1; calStM = 0; eDone = 1;
        end else calLineM++;
      end
      if (lineOnM) begin
        if (onCntM == ML - 1) begin
          for (int c = 0; c < NC; c++) onStM[c] = clampAvg(sumOn[c], ML);
          pendOnM = 1;
        end
        onCntM++;
        lineOnM = 0;
      end
    end else if (fEnd && calStM == 2) calStM = 1;
    if (fStart) begin
      if (pendOffM) begin offCoefM = offStM; pendOffM = 0; end
      if (pendOnM) begin onCoefM = onStM; pendOnM = 0; end
      onCntM = 0;
      if (calStM == 1) begin calStM = 2; calLineM = 0; end
    end
    if (cs && calStM == 0 && fullRes) calStM = 1;
    prevLv = lv; prevFv = fv;
    @(posedge clk);
    @(negedge clk);
    check("R13", int'(lineValidOut), int'(lv), "lineValidOut");
    check("R13", int'(frameValidOut), int'(fv), "frameValidOut");
    check(tag, int'(pixOut), ePix, "pixOut");
    check("R8", int'(calDone), int'(eDone), "calDone");
  endtask

  function automatic int pixVal(int kind, int seed, int ln, int col);
    if (kind == 1) begin
      if (col == 0) return 0;
      if (col == 1) return 300 + (ln % 2);
      return 20 * col + (ln % 4);
    end
    if (kind == 2 && ln < 4) return 10 + 3 * col + ln + seed;
    if (kind == 2 && ln == 4) return 900;
    if (ln == 0) return 5 * col;
    return (seed * 37 + ln * 53 + col * 101) % 4096;
  endfunction

  task automatic frame(int nLines, int kind, int seed);
    tick(0, 1, 0, 0, 0);
    tick(0, 1, 0, 0, 0);
    for (int ln = 0; ln < nLines; ln++) begin
      for (int c = 0; c < NC; c++)
        tick(1, 1, pixVal(kind, seed, ln, c), (kind == 2 && ln < 5), 0);
      tick(0, 1, 0, 0, 0);
      tick(0, 1, 0, 0, 0);
    end
    tick(0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      offCoefM[c] = 0; onCoefM[c] = 0; offStM[c] = 0; onStM[c] = 0;
      sumCal[c] = 0; sumOn[c] = 0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(pixOut), 0, "pixOut after reset");
    check("R1", int'(lineValidOut), 0, "lineValidOut after reset");
    check("R1", int'(calDone), 0, "calDone after reset");
    check("R1", int'(ovfFlag), 0, "ovfFlag after reset");
    check("R1", int'(unfFlag), 0, "unfFlag after reset");

    curTag = "R2"; corrMode = 2'b00; frame(4, 0, 1);
    corrMode = 2'b10; frame(3, 0, 2);

    // R9: request without full resolution is dropped
    curTag = "R9"; corrMode = 2'b01; fullRes = 1'b0;
    tick(0, 0, 0, 0, 1);
    frame(CL + 1, 1, 0);
    frame(3, 0, 3);
    check("R9", int'(ovfFlag), 0, "ovfFlag after rejected request");
    check("R9", int'(unfFlag), 0, "unfFlag after rejected request");

    // R5/R10: calibration frame, old table stays in use until next frame
    curTag = "R10"; fullRes = 1'b1;
    tick(0, 0, 0, 0, 1);
    frame(CL + 2, 1, 0);
    check("R6", int'(unfFlag), 1, "unfFlag after dark column");
    check("R7", int'(ovfFlag), 1, "ovfFlag after bright column");

    curTag = "R5"; frame(4, 0, 4);
    curTag = "R3"; frame(3, 0, 8);

    // R11: online table from masked lines
    curTag = "R11"; corrMode = 2'b11;
    frame(8, 2, 5);
    frame(6, 2, 9);
    frame(3, 0, 7);

    check("R12", int'(ovfFlag), 1, "ovfFlag still set");
    check("R12", int'(unfFlag), 1, "unfFlag still set");

    curTag = "R2"; corrMode = 2'b00; frame(2, 0, 11);
    summary();
    $finish;
  end

endmodule